// File: doc/BRIEF.md
# Width-Adaptive Byte Data FIFO for a Memory-Card Data Path

This block moves data between a processor register interface and the byte-wide data stream of a memory card. Two 32-byte rings sit between the sides. The transmit ring collects bytes written by the processor, and the receive ring collects bytes from the card. Each side of the processor interface appears as a single register. An access of 1, 2 or 4 bytes packs or unpacks that many bytes, most significant byte first.

A data phase begins with a start pulse. The pulse empties both rings, latches the transfer direction, and loads a remaining-byte counter with block count times block length. The card side uses a byte valid/ready handshake and moves at most one byte per clock. The remaining count decides three things: when the card side may move, when the processor is asked for more transmit data, and when the phase ends with its completion flags. Card framing, CRC and timeouts are handled elsewhere.

Top module: `xfer_byte_path`

## Requirements
- R1: Each ring holds exactly 32 bytes, and its read and write positions wrap modulo 32. Byte order is kept across the wrap, and a ring never reports more than 32 bytes.
- R2: A transmit write of width code w (00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes) takes bytes from the data word starting at bit position (n-1)*8 and moving down to bit 0, where n is the byte count. The write stops as soon as the transmit ring is full, and the rest of the bytes are dropped.
- R3: A receive read of width code w (same encoding as R2) pops bytes into positions (n-1)*8 downward. It stops early when the ring is empty, and every byte it did not fill reads as zero. The read word appears on rx_rdata_o one clock after the read strobe and holds until the next read.
- R4: tx_req_o is set while a write-direction phase is active, bytes remain, and the transmit ring is empty. It is also set by a start in write direction with a non-zero length. Any transmit write clears it.
- R5: In read direction, card_rx_ready_o is high only while the phase is active, bytes remain, and the receive ring holds fewer than 32 bytes. Each accepted card byte sets rx_req_o. A receive read clears rx_req_o unless a card byte is accepted in the same cycle, in which case the request stays set.
- R6: A start pulse loads the remaining count with blk_cnt_i times blk_len_i (12-bit length, 16-bit count), empties both rings, and clears both completion flags.
- R7: When the remaining count reaches zero, the phase goes idle in the same clock and data_done_o is set. prog_done_o is also set when the direction is write. A zero-length start sets both flags at once for write direction.
- R8: A flush pulse discards every byte waiting in the transmit ring. Those bytes are never offered to the card.
- R9: card_tx_valid_o is high only during an active write-direction phase with a non-empty transmit ring. At most one byte moves per clock, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a data phase |
| dir_wr_i | input | 1 | Direction at start: 1 = to card, 0 = from card |
| blk_len_i | input | 12 | Block length in bytes |
| blk_cnt_i | input | 16 | Number of blocks |
| acc_width_i | input | 2 | Access width code for register accesses |
| tx_wr_i | input | 1 | Transmit register write strobe |
| tx_wdata_i | input | 32 | Transmit register write data |
| flush_i | input | 1 | Discard pending transmit bytes |
| rx_rd_i | input | 1 | Receive register read strobe |
| rx_rdata_o | output | 32 | Receive register read data |
| tx_req_o | output | 1 | Transmit service request |
| rx_req_o | output | 1 | Receive service request |
| data_done_o | output | 1 | Data phase finished |
| prog_done_o | output | 1 | Write-direction phase finished |
| busy_o | output | 1 | Data phase active |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_valid_o | output | 1 | Byte to the card is valid |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| card_rx_data_i | input | 8 | Byte from the card |
| card_rx_valid_i | input | 1 | Byte from the card is valid |
| card_rx_ready_o | output | 1 | Block accepts the card byte |

## Verification
A receive read that pops the ring and a card byte that lands in it can share one clock. Both act on the receive ring count and on rx_req_o. The bench provokes this by raising rx_rd_i and card_rx_valid_i on the same falling edge. It then judges the result three ways: the popped byte comes out correctly, the request stays set, and a second read returns the byte that arrived. A flush issued while the card side is stalled is also checked, by confirming that no discarded byte is ever offered.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10
  } acc_width_e;

  // number of bytes moved by one register access
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      ACC_BYTE: width_bytes = 3'd1;
      ACC_HALF: width_bytes = 3'd2;
      default:  width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
  parameter int DEPTH  = 32,
  parameter int PUSH_N = 4,
  parameter int POP_N  = 1,
  parameter int BW     = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(PUSH_N + 1),
  localparam int QW = $clog2(POP_N + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic [PW-1:0]       push_req_i,
  input  logic [PUSH_N*BW-1:0] push_data_i,
  input  logic [QW-1:0]       pop_req_i,
  output logic [PW-1:0]       push_acc_o,
  output logic [QW-1:0]       pop_acc_o,
  output logic [POP_N*BW-1:0] peek_o,
  output logic [CW-1:0]       count_o
);

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q, free_w;

  // accepted amounts are clipped by space and by occupancy
  always_comb begin
    free_w = CW'(DEPTH) - count_q;
    if (clear_i) begin
      push_acc_o = '0;
      pop_acc_o  = '0;
    end else begin
      if (CW'(push_req_i) > free_w) push_acc_o = free_w[PW-1:0];
      else                          push_acc_o = push_req_i;
      if (CW'(pop_req_i) > count_q) pop_acc_o = count_q[QW-1:0];
      else                          pop_acc_o = pop_req_i;
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_N; k++) begin
      if (PW'(k) < push_acc_o) mem[wr_q + AW'(k)] <= push_data_i[k*BW +: BW];
    end
  end

  always_comb begin
    for (int k = 0; k < POP_N; k++) peek_o[k*BW +: BW] = mem[rd_q + AW'(k)];
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      wr_q    <= wr_q + AW'(push_acc_o);
      rd_q    <= rd_q + AW'(pop_acc_o);
      count_q <= count_q + CW'(push_acc_o) - CW'(pop_acc_o);
    end
  end

  assign count_o = count_q;

  // R1: occupancy never exceeds the ring size
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int REM_W = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             move_i,
  output logic             active_o,
  output logic             dir_o,
  output logic             data_done_o,
  output logic             prog_done_o
);

  logic [REM_W-1:0] rem_q, product_w, rem_dec_w;
  logic             active_q, dir_q, data_done_q, prog_done_q;

  assign product_w = REM_W'(blk_len_i) * REM_W'(blk_cnt_i);
  assign rem_dec_w = rem_q - REM_W'(move_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q       <= '0;
      active_q    <= 1'b0;
      dir_q       <= 1'b0;
      data_done_q <= 1'b0;
      prog_done_q <= 1'b0;
    end else if (start_i) begin
      rem_q       <= product_w;
      active_q    <= (product_w != '0);
      dir_q       <= dir_wr_i;
      data_done_q <= (product_w == '0);
      prog_done_q <= (product_w == '0) && dir_wr_i;
    end else if (active_q) begin
      rem_q <= rem_dec_w;
      if (rem_dec_w == '0) begin
        active_q    <= 1'b0;
        data_done_q <= 1'b1;
        prog_done_q <= dir_q;
      end
    end
  end

  assign active_o    = active_q;
  assign dir_o       = dir_q;
  assign data_done_o = data_done_q;
  assign prog_done_o = prog_done_q;

  // R7: a byte only moves while bytes remain
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    move_i |-> (active_q && rem_q != '0));

  // R7: completion and activity are exclusive
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    data_done_q |-> !active_q);

  // R6: start loads the product
  p_start_load_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> rem_q == $past(product_w));

endmodule

// File: rtl/xfer_byte_path.sv
module xfer_byte_path
  import xfer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [1:0]       acc_width_i,
  input  logic             tx_wr_i,
  input  logic [31:0]      tx_wdata_i,
  input  logic             flush_i,
  input  logic             rx_rd_i,
  output logic [31:0]      rx_rdata_o,
  output logic             tx_req_o,
  output logic             rx_req_o,
  output logic             data_done_o,
  output logic             prog_done_o,
  output logic             busy_o,
  output logic [7:0]       card_tx_data_o,
  output logic             card_tx_valid_o,
  input  logic             card_tx_ready_i,
  input  logic [7:0]       card_rx_data_i,
  input  logic             card_rx_valid_i,
  output logic             card_rx_ready_o
);

  localparam int BW    = 8;
  localparam int LANES = 4;
  localparam int LW    = $clog2(LANES + 1);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [2:0]          nb_w;
  logic [LANES*BW-1:0] tx_push_bytes, rx_peek, rx_word;
  logic [LW-1:0]       tx_push_acc, rx_pop_acc;
  logic [0:0]          tx_pop_acc, rx_push_acc;
  logic [BW-1:0]       tx_peek;
  logic [CW-1:0]       tx_count, rx_count;
  logic                active, dir_wr, tx_move, rx_move;
  logic                tx_req_q, rx_req_q;
  logic [31:0]         rx_rdata_q;

  assign nb_w = width_bytes(acc_width_i);

  // most significant byte of the access goes first
  always_comb begin
    tx_push_bytes = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nb_w)) tx_push_bytes[k*BW +: BW] = tx_wdata_i[(int'(nb_w)-1-k)*BW +: BW];
    end
  end

  always_comb begin
    rx_word = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(rx_pop_acc)) rx_word[(int'(nb_w)-1-k)*BW +: BW] = rx_peek[k*BW +: BW];
    end
  end

  assign card_tx_valid_o = active && dir_wr && (tx_count != '0);
  assign card_rx_ready_o = active && !dir_wr && (rx_count < CW'(DEPTH));
  assign tx_move = card_tx_valid_o && card_tx_ready_i;
  assign rx_move = card_rx_valid_i && card_rx_ready_o;

  byte_ring #(.DEPTH(DEPTH), .PUSH_N(LANES), .POP_N(1), .BW(BW)) i_tx_ring (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start_i || flush_i),
    .push_req_i  (tx_wr_i ? LW'(nb_w) : LW'(0)),
    .push_data_i (tx_push_bytes),
    .pop_req_i   (tx_move),
    .push_acc_o  (tx_push_acc),
    .pop_acc_o   (tx_pop_acc),
    .peek_o      (tx_peek),
    .count_o     (tx_count)
  );

  byte_ring #(.DEPTH(DEPTH), .PUSH_N(1), .POP_N(LANES), .BW(BW)) i_rx_ring (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start_i),
    .push_req_i  (rx_move),
    .push_data_i (card_rx_data_i),
    .pop_req_i   (rx_rd_i ? LW'(nb_w) : LW'(0)),
    .push_acc_o  (rx_push_acc),
    .pop_acc_o   (rx_pop_acc),
    .peek_o      (rx_peek),
    .count_o     (rx_count)
  );

  xfer_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_ctl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dir_wr_i    (dir_wr_i),
    .blk_len_i   (blk_len_i),
    .blk_cnt_i   (blk_cnt_i),
    .move_i      (tx_move || rx_move),
    .active_o    (active),
    .dir_o       (dir_wr),
    .data_done_o (data_done_o),
    .prog_done_o (prog_done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req_q   <= 1'b0;
      rx_req_q   <= 1'b0;
      rx_rdata_q <= '0;
    end else begin
      if (start_i)      tx_req_q <= dir_wr_i && (blk_len_i != '0) && (blk_cnt_i != '0);
      else if (tx_wr_i) tx_req_q <= 1'b0;
      else if (active && dir_wr && tx_count == '0) tx_req_q <= 1'b1;

      if (start_i)      rx_req_q <= 1'b0;
      else if (rx_move) rx_req_q <= 1'b1;
      else if (rx_rd_i) rx_req_q <= 1'b0;

      if (rx_rd_i) rx_rdata_q <= rx_word;
    end
  end

  assign tx_req_o       = tx_req_q;
  assign rx_req_o       = rx_req_q;
  assign rx_rdata_o     = rx_rdata_q;
  assign busy_o         = active;
  assign card_tx_data_o = tx_peek;

  // R9: the card is offered a byte only when one is stored
  p_tx_valid_r9: assert property (@(posedge clk) disable iff (rst)
    card_tx_valid_o |-> (tx_count != '0 && busy_o));

  // R9: a handshake removes exactly one byte
  p_tx_pop_r9: assert property (@(posedge clk) disable iff (rst)
    tx_move |-> tx_pop_acc == 1'b1);

  // R5: the card is never accepted into a full ring
  p_rx_ready_r5: assert property (@(posedge clk) disable iff (rst)
    card_rx_ready_o |-> rx_count < CW'(DEPTH));

  // R5: an accepted card byte is stored
  p_rx_push_r5: assert property (@(posedge clk) disable iff (rst)
    rx_move |-> rx_push_acc == 1'b1);

  // R2: a write never stores more than the access width
  p_tx_width_r2: assert property (@(posedge clk) disable iff (rst)
    tx_wr_i |-> tx_push_acc <= LW'(nb_w));

endmodule

// File: tb/test_xfer_byte_path.sv
`timescale 1ns/1ps
module test_xfer_byte_path;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, dir_wr_i, tx_wr_i, flush_i, rx_rd_i;
  logic [11:0] blk_len_i;
  logic [15:0] blk_cnt_i;
  logic [1:0]  acc_width_i;
  logic [31:0] tx_wdata_i, rx_rdata_o;
  logic        tx_req_o, rx_req_o, data_done_o, prog_done_o, busy_o;
  logic [7:0]  card_tx_data_o, card_rx_data_i;
  logic        card_tx_valid_o, card_tx_ready_i, card_rx_valid_i, card_rx_ready_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xfer_byte_path i_xfer_byte_path (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_wr_i(dir_wr_i),
    .blk_len_i(blk_len_i), .blk_cnt_i(blk_cnt_i), .acc_width_i(acc_width_i),
    .tx_wr_i(tx_wr_i), .tx_wdata_i(tx_wdata_i), .flush_i(flush_i),
    .rx_rd_i(rx_rd_i), .rx_rdata_o(rx_rdata_o), .tx_req_o(tx_req_o),
    .rx_req_o(rx_req_o), .data_done_o(data_done_o), .prog_done_o(prog_done_o),
    .busy_o(busy_o), .card_tx_data_o(card_tx_data_o),
    .card_tx_valid_o(card_tx_valid_o), .card_tx_ready_i(card_tx_ready_i),
    .card_rx_data_i(card_rx_data_i), .card_rx_valid_i(card_rx_valid_i),
    .card_rx_ready_o(card_rx_ready_o)
  );

  // width code, write data, expected card bytes (first byte in [31:24])
  localparam logic [65:0] TX_VEC [6] = '{
    {2'b00, 32'h123456AB, 32'hAB000000},
    {2'b01, 32'h1234CDEF, 32'hCDEF0000},
    {2'b10, 32'hDEADBEEF, 32'hDEADBEEF},
    {2'b11, 32'h01020304, 32'h01020304},
    {2'b01, 32'hFFFF0011, 32'h00110000},
    {2'b00, 32'h0000005A, 32'h5A000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic dir, input logic [15:0] cnt, input logic [11:0] len);
    start_i = 1'b1; dir_wr_i = dir; blk_cnt_i = cnt; blk_len_i = len;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic tx_write(input logic [1:0] w, input logic [31:0] d);
    tx_wr_i = 1'b1; acc_width_i = w; tx_wdata_i = d;
    @(negedge clk);
    tx_wr_i = 1'b0;
  endtask

  task automatic rx_read(input logic [1:0] w);
    rx_rd_i = 1'b1; acc_width_i = w;
    @(negedge clk);
    rx_rd_i = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    card_rx_valid_i = 1'b1; card_rx_data_i = b;
    @(negedge clk);
    card_rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %h expected %h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 0; dir_wr_i = 0; blk_len_i = 0; blk_cnt_i = 0;
    acc_width_i = 0; tx_wr_i = 0; tx_wdata_i = 0; flush_i = 0; rx_rd_i = 0;
    card_tx_ready_i = 1'b1; card_rx_data_i = 0; card_rx_valid_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R7 reset busy", busy_o, 0);
    chk("R7 reset done", {data_done_o, prog_done_o}, 0);
    chk("R4 reset tx_req", tx_req_o, 0);
    chk("R5 reset rx_req", rx_req_o, 0);
    chk("R9 reset tx valid", card_tx_valid_o, 0);
    chk("R5 reset rx ready", card_rx_ready_o, 0);
    chk("R3 reset rdata", rx_rdata_o, 0);

    // table of transmit packings
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  w;
      logic [31:0] got;
      int n, nb;
      w = TX_VEC[v][65:64];
      nb = (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
      got = 0; n = 0;
      do_start(1'b1, 16'd1, 12'(nb));
      chk("R4 tx_req after start", tx_req_o, 1);
      tx_write(w, TX_VEC[v][63:32]);
      for (int c = 0; c < 8; c++) begin
        if (card_tx_valid_o) begin
          got = got | (32'(card_tx_data_o) << (24 - 8*n));
          n++;
        end
        @(negedge clk);
      end
      chk("R2 packed bytes", got, TX_VEC[v][31:0]);
      chk("R9 byte count", n, nb);
      chk("R7 write done flags", {data_done_o, prog_done_o, busy_o}, 3'b110);
    end

    // fill the transmit ring past its size with the card stalled
    card_tx_ready_i = 1'b0;
    do_start(1'b1, 16'd1, 12'd64);
    for (int j = 0; j < 9; j++) begin
      tx_write(2'b10, {8'(4*j), 8'(4*j+1), 8'(4*j+2), 8'(4*j+3)});
      if (j == 0) chk("R4 write clears tx_req", tx_req_o, 0);
    end
    card_tx_ready_i = 1'b1;
    begin
      int n;
      n = 0;
      for (int c = 0; c < 40; c++) begin
        if (card_tx_valid_o) begin
          if (card_tx_data_o !== 8'(n)) chk("R9 byte order", card_tx_data_o, n);
          n++;
        end
        @(negedge clk);
      end
      chk("R2 full ring stops write", n, 32);
    end
    chk("R4 tx_req when empty with bytes left", tx_req_o, 1);
    chk("R7 still busy", busy_o, 1);

    // indices have wrapped; order must survive
    tx_write(2'b10, 32'hA0A1A2A3);
    begin
      logic [31:0] got;
      got = 0;
      for (int c = 0; c < 4; c++) begin
        got = {got[23:0], card_tx_data_o};
        @(negedge clk);
      end
      chk("R1 wrap order", got, 32'hA0A1A2A3);
    end

    // flush with the card stalled
    card_tx_ready_i = 1'b0;
    tx_write(2'b10, 32'h11223344);
    chk("R9 valid before flush", card_tx_valid_o, 1);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    card_tx_ready_i = 1'b1;
    @(negedge clk);
    chk("R8 flush drops bytes", card_tx_valid_o, 0);
    @(negedge clk);
    chk("R8 tx_req after flush", tx_req_o, 1);

    // receive, partial read with zero fill
    do_start(1'b0, 16'd1, 12'd3);
    chk("R5 rx ready", card_rx_ready_o, 1);
    chk("R6 start clears done", data_done_o, 0);
    feed(8'hA1); feed(8'hB2); feed(8'hC3);
    chk("R5 rx_req raised", rx_req_o, 1);
    chk("R7 read done flags", {data_done_o, prog_done_o, busy_o}, 3'b100);
    chk("R5 not ready when idle", card_rx_ready_o, 0);
    rx_read(2'b10);
    chk("R3 short read zero fill", rx_rdata_o, 32'hA1B2C300);
    chk("R5 read clears rx_req", rx_req_o, 0);
    rx_read(2'b01);
    chk("R3 empty read", rx_rdata_o, 0);

    // read and card arrival in the same clock
    do_start(1'b0, 16'd1, 12'd4);
    feed(8'h10);
    rx_rd_i = 1'b1; acc_width_i = 2'b00;
    card_rx_valid_i = 1'b1; card_rx_data_i = 8'h20;
    @(negedge clk);
    rx_rd_i = 1'b0; card_rx_valid_i = 1'b0;
    chk("R3 byte read", rx_rdata_o, 32'h00000010);
    chk("R5 collision keeps rx_req", rx_req_o, 1);
    rx_read(2'b01);
    chk("R3 half read", rx_rdata_o, 32'h00002000);
    chk("R5 rx_req cleared", rx_req_o, 0);

    // start empties the rings
    feed(8'h30);
    do_start(1'b0, 16'd1, 12'd2);
    rx_read(2'b10);
    chk("R6 start empties rx", rx_rdata_o, 0);
    chk("R6 busy after start", busy_o, 1);

    // fill the receive ring
    do_start(1'b0, 16'd1, 12'd40);
    begin
      int acc;
      acc = 0;
      for (int c = 0; c < 36; c++) begin
        card_rx_valid_i = 1'b1;
        card_rx_data_i = 8'(acc);
        if (card_rx_ready_o) acc++;
        @(negedge clk);
      end
      card_rx_valid_i = 1'b0;
      chk("R5 ring accepts 32", acc, 32);
    end
    chk("R5 ready low when full", card_rx_ready_o, 0);
    for (int j = 0; j < 8; j++) begin
      rx_read(2'b10);
      chk("R1 rx order", rx_rdata_o, {8'(4*j), 8'(4*j+1), 8'(4*j+2), 8'(4*j+3)});
    end
    chk("R5 ready again", card_rx_ready_o, 1);

    // block count times block length
    do_start(1'b0, 16'd2, 12'd3);
    for (int j = 0; j < 5; j++) feed(8'(j));
    chk("R6 not done at 5 of 6", {data_done_o, busy_o}, 2'b01);
    feed(8'h55);
    chk("R6 done at 6", {data_done_o, busy_o}, 2'b10);

    // zero-length phase
    do_start(1'b1, 16'd0, 12'd5);
    chk("R7 zero length", {data_done_o, prog_done_o, busy_o}, 3'b110);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule